// File: doc/BRIEF.md
# Block-Threshold Cyclic Receive FIFO

This block is a circular byte store that sits between a receive address filter and a host microcontroller. Frames arrive one byte per cycle, and the last byte of each frame carries a frame-end marker. The host does not read byte by byte on demand. Instead, the FIFO offers it one block at a time and raises an interrupt. The interrupt says either that a full block of the selected size is waiting (pool full) or that the tail of a frame is waiting (message end). In the second case the FIFO also reports how many bytes that tail holds.

The host reads the presented bytes through a sequential read port. It then issues a release command, which frees exactly the presented bytes and moves the read base forward. A 2-bit block-size field selects the threshold. A build-time parameter selects the channel flavour: a narrow channel has 64 bytes of storage and blocks of 4, 8, 16 or 32 bytes, and a wide channel has 128 bytes and blocks of 8, 16, 32 or 64 bytes. A flush command returns the FIFO to empty. A write that finds no room sets a sticky overflow flag. The rest of that frame is discarded, and whatever part of it was already stored is closed off as a message.

Top module: `rx_block_fifo`

## Requirements
- R1: After rst_n is released, fill_count is 0, irq, irq_pool and irq_end are low, and overflow is low.
- R2: The block size is BASE << blk_sel, where BASE is 4 for the narrow channel (WIDE_CHAN=0, 64 bytes) and 8 for the wide channel (WIDE_CHAN=1, 128 bytes). fill_count never exceeds the storage depth.
- R3: If at least one block of unreleased bytes is stored, and the oldest stored frame end is not within one block of the read base, irq_pool and irq rise within three cycles and blk_cnt equals the block size. With one byte less, no interrupt is raised.
- R4: When the oldest stored frame has at most one block size of bytes left from the read base, irq_end and irq rise instead, and blk_cnt gives that remaining byte count. This applies even when the remainder equals the block size. irq_pool and irq_end are never high together.
- R5: While a block is presented, rd_data shows the stored bytes in write order, starting at the first byte of the block, and each rd_en pulse moves to the next byte.
- R6: cmd_release while a block is presented lowers irq on the next cycle, reduces fill_count by blk_cnt, and makes the next presented block start right after the released one.
- R7: cmd_release while nothing is presented changes neither fill_count nor the data that is presented later.
- R8: A write that finds the store full (fill_count equal to the depth) sets overflow. overflow stays high until a flush or reset. That byte and every later byte of the same frame, up to and including its frame-end byte, are dropped. The bytes of the frame that were already stored are presented as a message end.
- R9: cmd_flush empties the FIFO, clears any presented block and clears overflow. The next frame is then stored from a clean state.
- R10: When FRAME_SLOTS frame ends are pending and unreleased, the first byte of a new frame counts as a full-store write under R8.
- R11: While a block is presented and not released, blk_cnt and the interrupt kind hold, even if blk_sel changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_sel | input | 2 | Block-size select (BASE << blk_sel) |
| wr_valid | input | 1 | A received byte is offered this cycle |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | Offered byte is the last of its frame |
| rd_en | input | 1 | Host advances to the next byte of the presented block |
| rd_data | output | 8 | Byte at the host read position |
| cmd_release | input | 1 | Host releases the presented block |
| cmd_flush | input | 1 | Host empties the FIFO and clears overflow |
| irq | output | 1 | A block is presented |
| irq_pool | output | 1 | Presented block is a full threshold block |
| irq_end | output | 1 | Presented block ends a frame |
| blk_cnt | output | CW | Byte count of the presented block |
| fill_count | output | CW | Stored, unreleased bytes |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The checker assumes that the host releases only a block it has been shown. It also assumes that the host pulses rd_en no more than blk_cnt times per block and never writes and releases in the same cycle that a release rule is checked. The bench's host tasks follow this discipline: they wait until the interrupt is up, read exactly the reported count, and only then pulse cmd_release while the write port is idle. Writes, releases and flushes are driven as single-cycle pulses one nanosecond after a clock edge, so every command is sampled cleanly on the next edge.

// File: rtl/rxbf_pkg.sv
// Shared types for the block-threshold receive FIFO.
package rxbf_pkg;
    // What the FIFO currently offers the host.
    typedef enum logic [1:0] {
        PR_IDLE = 2'd0,
        PR_POOL = 2'd1,
        PR_END  = 2'd2
    } pres_e;
endpackage

// File: rtl/rxbf_store.sv
// Byte storage: one synchronous write port and one combinational read port.
// Assumes DEPTH is a power of two, so the address simply wraps.
module rxbf_store #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxbf_len_q.sv
// Queue of completed frame lengths, oldest frame at the head.
// Assumes SLOTS is a power of two and that pop is only issued when an entry exists.
module rxbf_len_q #(
    parameter int SLOTS = 4,
    parameter int LW    = 7,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [LW-1:0] push_len,
    input  logic          pop,
    output logic [LW-1:0] head,
    output logic          has_entry,
    output logic          full
);
    logic [LW-1:0] slot [SLOTS];
    logic [SW-1:0] wp, rp;
    logic [SW:0]   cnt;

    // Advance the write/read pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + (SW+1)'(push) - (SW+1)'(pop);
        end
    end

    // Record the length of a finished frame.
    always_ff @(posedge clk) begin
        if (push) slot[wp] <= push_len;
    end

    assign head      = slot[rp];
    assign has_entry = (cnt != '0);
    assign full      = (cnt == (SW+1)'(SLOTS));
endmodule

// File: rtl/rxbf_present.sv
// Chooses which block is offered to the host and holds it until it is released.
// A frame tail has priority over a full block. The choice is made only from idle,
// so a presented block never changes under the host.
module rxbf_present #(
    parameter int CW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CW-1:0]     fill,
    input  logic [CW-1:0]     blk,
    input  logic              has_end,
    input  logic [CW-1:0]     rem,
    input  logic              release_req,
    output rxbf_pkg::pres_e   state,
    output logic [CW-1:0]     cnt,
    output logic              fire
);
    import rxbf_pkg::*;

    assign fire = release_req && (state != PR_IDLE);

    // Present the next block from idle; go back to idle on release.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= PR_IDLE;
            cnt   <= '0;
        end else if (fire) begin
            state <= PR_IDLE;
            cnt   <= '0;
        end else if (state == PR_IDLE) begin
            if (has_end && rem <= blk) begin
                state <= PR_END;
                cnt   <= rem;
            end else if (fill >= blk) begin
                state <= PR_POOL;
                cnt   <= blk;
            end
        end
    end
endmodule

// File: rtl/rx_block_fifo.sv
// Block-threshold cyclic receive FIFO (top).
// Bytes are written with a frame-end flag. The host is offered one block at a
// time through irq/irq_pool/irq_end, reads it with rd_en and frees it with
// cmd_release. Assumes the host reads at most blk_cnt bytes per block.
module rx_block_fifo #(
    parameter int WIDE_CHAN   = 0,
    parameter int FRAME_SLOTS = 4,
    localparam int DEPTH      = (WIDE_CHAN != 0) ? 128 : 64,
    localparam int BASE_BLK   = (WIDE_CHAN != 0) ? 8 : 4,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    blk_sel,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_last,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic          cmd_release,
    input  logic          cmd_flush,
    output logic          irq,
    output logic          irq_pool,
    output logic          irq_end,
    output logic [CW-1:0] blk_cnt,
    output logic [CW-1:0] fill_count,
    output logic          overflow
);
    import rxbf_pkg::*;

    logic [CW-1:0] wr_ptr, base_ptr, rd_ptr;
    logic [CW-1:0] cur_len, used;
    logic          dropping, ovf_q;
    logic [CW-1:0] fill, blk, rem, q_head, pres_cnt, push_len;
    logic          q_has, q_full, full_now, accept, ovf_hit, push, pop, fire;
    pres_e         pres_state;

    assign fill     = wr_ptr - base_ptr;
    assign blk      = CW'(BASE_BLK) << blk_sel;
    assign rem      = q_head - used;
    assign full_now = (fill == CW'(DEPTH)) || (cur_len == '0 && q_full);
    assign accept   = wr_valid && !cmd_flush && !dropping && !full_now;
    assign ovf_hit  = wr_valid && !cmd_flush && !dropping && full_now;
    assign push     = (accept && wr_last) || (ovf_hit && cur_len != '0);
    assign push_len = accept ? cur_len + 1'b1 : cur_len;
    assign pop      = fire && (pres_state == PR_END);

    rxbf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (accept),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    rxbf_len_q #(.SLOTS(FRAME_SLOTS), .LW(CW)) u_lenq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_flush),
        .push      (push),
        .push_len  (push_len),
        .pop       (pop),
        .head      (q_head),
        .has_entry (q_has),
        .full      (q_full)
    );

    rxbf_present #(.CW(CW)) u_pres (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (cmd_flush),
        .fill        (fill),
        .blk         (blk),
        .has_end     (q_has),
        .rem         (rem),
        .release_req (cmd_release),
        .state       (pres_state),
        .cnt         (pres_cnt),
        .fire        (fire)
    );

    // Write side: advance on accepted bytes, track the frame length, and handle overflow drop.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_flush) begin
            wr_ptr   <= '0;
            cur_len  <= '0;
            dropping <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            if (accept) begin
                wr_ptr  <= wr_ptr + 1'b1;
                cur_len <= wr_last ? '0 : cur_len + 1'b1;
            end
            if (ovf_hit) begin
                ovf_q    <= 1'b1;
                cur_len  <= '0;
                dropping <= !wr_last;
            end
            if (dropping && wr_valid && wr_last) dropping <= 1'b0;
        end
    end

    // Host side: free released bytes, set the next read base, step within a block.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_flush) begin
            base_ptr <= '0;
            rd_ptr   <= '0;
            used     <= '0;
        end else if (fire) begin
            base_ptr <= base_ptr + pres_cnt;
            rd_ptr   <= base_ptr + pres_cnt;
            used     <= (pres_state == PR_END) ? '0 : used + pres_cnt;
        end else if (rd_en && pres_state != PR_IDLE) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign irq        = (pres_state != PR_IDLE);
    assign irq_pool   = (pres_state == PR_POOL);
    assign irq_end    = (pres_state == PR_END);
    assign blk_cnt    = pres_cnt;
    assign fill_count = fill;
    assign overflow   = ovf_q;
endmodule

// File: rtl/rx_block_fifo_chk.sv
// Port-level temporal checks for rx_block_fifo, attached by bind.
// Assumes the host releases only while irq is high.
module rx_block_fifo_chk #(
    parameter int CW    = 7,
    parameter int DEPTH = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          cmd_release,
    input logic          cmd_flush,
    input logic          irq,
    input logic          irq_pool,
    input logic          irq_end,
    input logic [CW-1:0] blk_cnt,
    input logic [CW-1:0] fill_count,
    input logic          overflow
);
    // R1: a cleanly released reset leaves the FIFO empty and quiet.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fill_count == '0 && !irq && !overflow));

    // R2: occupancy never goes beyond the storage depth.
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    // R3: a presented full block is backed by stored bytes.
    a_r3_pool_backed: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pool |-> fill_count >= blk_cnt);

    // R4: only one interrupt kind at a time, and a message end is never empty.
    a_r4_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pool && irq_end) && (!irq_end || blk_cnt != '0));

    // R6: a release frees exactly the presented count and lowers the interrupt.
    a_r6_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cmd_release && !cmd_flush && !wr_valid) |=>
            (!irq && fill_count == $past(fill_count) - $past(blk_cnt)));

    // R7: a release with nothing presented leaves occupancy alone.
    a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && cmd_release && !cmd_flush && !wr_valid) |=> $stable(fill_count));

    // R8: overflow is sticky until a flush.
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !cmd_flush) |=> overflow);

    // R9: a flush empties the FIFO and clears everything pending.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flush |=> (fill_count == '0 && !irq && !overflow));

    // R11: a presented block holds its count and kind until it is released.
    a_r11_block_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cmd_release && !cmd_flush) |=>
            (irq && $stable(blk_cnt) && $stable(irq_pool)));
endmodule

bind rx_block_fifo rx_block_fifo_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .cmd_release (cmd_release),
    .cmd_flush   (cmd_flush),
    .irq         (irq),
    .irq_pool    (irq_pool),
    .irq_end     (irq_end),
    .blk_cnt     (blk_cnt),
    .fill_count  (fill_count),
    .overflow    (overflow)
);

// File: tb/rx_block_fifo_test.sv
// Directed bench: each task runs one scenario and checks its own results.
module rx_block_fifo_test;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    blk_sel = 2'd0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          wr_last = 1'b0;
    logic          rd_en = 1'b0;
    logic          cmd_release = 1'b0;
    logic          cmd_flush = 1'b0;
    logic [7:0]    rd_data;
    logic          irq, irq_pool, irq_end, overflow;
    logic [CW-1:0] blk_cnt, fill_count;

    int   checks = 0;
    int   failures = 0;
    logic [7:0] model[$];
    logic [7:0] seq = 8'h01;

    rx_block_fifo uut (
        .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .rd_en(rd_en), .rd_data(rd_data),
        .cmd_release(cmd_release), .cmd_flush(cmd_flush),
        .irq(irq), .irq_pool(irq_pool), .irq_end(irq_end),
        .blk_cnt(blk_cnt), .fill_count(fill_count), .overflow(overflow)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Offer one byte; keep says whether the FIFO is expected to store it.
    task automatic put(input logic last, input logic keep);
        wr_valid = 1'b1; wr_data = seq; wr_last = last;
        if (keep) model.push_back(seq);
        seq = seq + 8'd1;
        @(posedge clk); #1;
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic put_frame(input int n, input logic ends, input int keep_n);
        for (int i = 0; i < n; i++) put(ends && (i == n - 1), i < keep_n);
    endtask

    task automatic expect_block(input string req, input int pool, input int cnt);
        check({req, " irq"}, int'(irq), 1);
        check({req, " irq_pool"}, int'(irq_pool), pool);
        check({req, " irq_end"}, int'(irq_end), 1 - pool);
        check({req, " blk_cnt"}, int'(blk_cnt), cnt);
    endtask

    // Read n bytes against the model, then release them (R5, R6).
    task automatic take_block(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            check({req, " R5 rd_data"}, int'(rd_data), int'(model[i]));
            rd_en = 1'b1; @(posedge clk); #1; rd_en = 1'b0;
        end
        cmd_release = 1'b1; @(posedge clk); #1; cmd_release = 1'b0;
        check({req, " R6 irq low after release"}, int'(irq), 0);
        for (int i = 0; i < n; i++) void'(model.pop_front());
        settle();
    endtask

    task automatic flush();
        cmd_flush = 1'b1; @(posedge clk); #1; cmd_flush = 1'b0;
        model.delete();
        settle();
    endtask

    task automatic t_reset();
        check("R1 fill", int'(fill_count), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_pool_then_end();
        blk_sel = 2'd1;
        put_frame(10, 1'b0, 10); settle();
        expect_block("R3 pool 8", 1, 8);
        check("R3 fill", int'(fill_count), 10);
        take_block("R3", 8);
        check("R6 fill after release", int'(fill_count), 2);
        check("R6 idle below threshold", int'(irq), 0);
        put_frame(3, 1'b1, 3); settle();
        expect_block("R4 tail 5", 0, 5);
        take_block("R4", 5);
        check("R6 empty", int'(fill_count), 0);
    endtask

    task automatic t_idle_release();
        put_frame(2, 1'b0, 2); settle();
        cmd_release = 1'b1; @(posedge clk); #1; cmd_release = 1'b0; settle();
        check("R7 fill unchanged", int'(fill_count), 2);
        check("R7 irq", int'(irq), 0);
        put_frame(1, 1'b1, 1); settle();
        expect_block("R7 tail 3", 0, 3);
        take_block("R7", 3);
    endtask

    task automatic t_block_sizes();
        for (int s = 0; s < 4; s++) begin
            int b;
            b = 4 << s;
            blk_sel = 2'(s);
            put_frame(b - 1, 1'b0, b - 1); settle();
            check("R3 no irq one short", int'(irq), 0);
            put_frame(1, 1'b0, 1); settle();
            expect_block("R2 block size", 1, b);
            take_block("R2", b);
            put_frame(1, 1'b1, 1); settle();
            expect_block("R4 tail 1", 0, 1);
            take_block("R4", 1);
        end
    endtask

    task automatic t_frame_ends();
        blk_sel = 2'd0;
        put_frame(4, 1'b1, 4); settle();
        expect_block("R4 tail equals block", 0, 4);
        take_block("R4", 4);
        blk_sel = 2'd2;
        put_frame(5, 1'b1, 5);
        put_frame(3, 1'b1, 3); settle();
        expect_block("R4 first frame", 0, 5);
        take_block("R4", 5);
        expect_block("R4 second frame", 0, 3);
        take_block("R4", 3);
    endtask

    task automatic t_latched();
        blk_sel = 2'd0;
        put_frame(4, 1'b0, 4); settle();
        expect_block("R11 before change", 1, 4);
        blk_sel = 2'd3; settle();
        expect_block("R11 after change", 1, 4);
        take_block("R11", 4);
        put_frame(1, 1'b1, 1); settle();
        expect_block("R11 tail", 0, 1);
        take_block("R11", 1);
    endtask

    task automatic t_overflow();
        blk_sel = 2'd3;
        put_frame(60, 1'b1, 60);
        put_frame(6, 1'b1, 4); settle();
        check("R8 overflow set", int'(overflow), 1);
        check("R8 fill at depth", int'(fill_count), 64);
        expect_block("R8 pool 32", 1, 32);
        take_block("R8", 32);
        expect_block("R8 tail 28", 0, 28);
        take_block("R8", 28);
        expect_block("R8 truncated frame", 0, 4);
        take_block("R8", 4);
        check("R8 sticky", int'(overflow), 1);
        check("R8 dropped bytes", int'(fill_count), 0);
        put_frame(2, 1'b1, 2); settle();
        expect_block("R8 next frame", 0, 2);
        take_block("R8", 2);
        flush();
        check("R9 overflow cleared", int'(overflow), 0);
    endtask

    task automatic t_slot_limit();
        blk_sel = 2'd3;
        for (int f = 0; f < 4; f++) put_frame(2, 1'b1, 2);
        put_frame(2, 1'b1, 0); settle();
        check("R10 overflow", int'(overflow), 1);
        check("R10 fill", int'(fill_count), 8);
        for (int f = 0; f < 4; f++) begin
            expect_block("R10 frame", 0, 2);
            take_block("R10", 2);
        end
        check("R10 empty", int'(fill_count), 0);
        flush();
    endtask

    task automatic t_flush();
        blk_sel = 2'd0;
        put_frame(5, 1'b0, 5); settle();
        expect_block("R9 pre", 1, 4);
        flush();
        check("R9 fill", int'(fill_count), 0);
        check("R9 irq", int'(irq), 0);
        check("R9 overflow", int'(overflow), 0);
        put_frame(3, 1'b1, 3); settle();
        expect_block("R9 clean frame", 0, 3);
        take_block("R9", 3);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        t_reset();
        t_pool_then_end();
        t_idle_release();
        t_block_sizes();
        t_frame_ends();
        t_latched();
        t_overflow();
        t_slot_limit();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule